// File: doc/BRIEF.md
# Serial Hexadecimal Word Printer

This block takes a 32-bit word when its start strobe is accepted and prints it on a serial transmit line as readable text. It sends eight hexadecimal characters, beginning with the most significant nibble. It then sends a line feed, so each word lands on its own line on a terminal. Each nibble is turned into an ASCII code as it goes out, so no text buffer is kept.

Internally, a baud tick generator runs at sixteen ticks per bit. Its period is set by a divisor parameter, worked out as the clock divided by sixteen times the baud rate, minus one. For example, 12 gives 115200 baud from 24 MHz. A sequencer walks through the nibbles and the terminator, and an 8N1 framer shifts each character out. A busy flag covers the whole word. A single-cycle done pulse marks the end of the line feed's stop bit.

Top module: `hexdump_uart`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `txd` is 1, `busy` is 0 and `done` is 0.
- R2: An accepted start sends exactly nine characters. The first eight carry the latched word's nibbles in the order bits 31:28, 27:24, down to bits 3:0.
- R3: A nibble of value 0 to 9 is sent as the byte value+0x30 (ASCII '0' to '9').
- R4: A nibble of value 10 to 15 is sent as the byte value+0x37 (ASCII 'A' to 'F').
- R5: The ninth character of every word is the line feed byte 0x0A.
- R6: Each character is framed as a start bit at 0, then eight data bits with the least significant bit first, then a stop bit at 1. Every bit lasts 16*(BAUD_DIV+1) clock cycles.
- R7: `busy` is 1 from the cycle after an accepted start until the cycle in which `done` pulses.
- R8: A start strobe while `busy` is 1 is ignored, and so is any change on `word_in` after acceptance. The output carries the word latched at acceptance, and no extra characters follow.
- R9: `done` is high for exactly one cycle, right after the line feed's stop bit ends. `busy` is already 0 in that cycle.
- R10: A start presented in the same cycle as `done` is accepted, and its word follows immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to print `word_in`; honoured only when not busy |
| word_in | input | 32 | Word to print, captured when a start is accepted |
| busy | output | 1 | High while a word is being printed |
| done | output | 1 | One-cycle pulse once the line feed has been fully sent |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The end of one word and the acceptance of the next can share a cycle. The done pulse and a fresh start strobe coincide, and the busy flag is already low then. The bench waits for done, samples it between clock edges, and raises start before the edge that closes that same cycle. It then expects busy to be high one cycle later. The bench's own serial receiver, timed from the divisor, must decode both lines correctly. A second hazard, a start arriving mid-word, is provoked with a different word and is judged by the absence of any extra frame.

// File: rtl/hexdump_pkg.sv
// Shared types and the nibble-to-character conversion for the hex word printer.
// Assumes ASCII output with upper-case letters for values 10 to 15.
package hexdump_pkg;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} seq_state_t;

    localparam logic [7:0] LINE_FEED = 8'h0A;

    // Map one nibble onto its printable hexadecimal character.
    function automatic logic [7:0] nibble_to_ascii(input logic [3:0] val);
        if (val < 4'd10)
            return 8'd48 + {4'h0, val};
        else
            return 8'd55 + {4'h0, val};
    endfunction

endpackage

// File: rtl/hexdump_baud.sv
// Oversampling tick generator: one tick every BAUD_DIV+1 clocks while run is high.
// Assumes the counter restarts from zero each time run rises, so bit timing is
// aligned to the start of a character.
module hexdump_baud #(
    parameter int DIV_W    = 16,
    parameter int BAUD_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = DIV_W'(BAUD_DIV);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count clocks inside one oversample period, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hexdump_tx.sv
// 8N1 serial framer: start bit low, eight data bits LSB first, stop bit high.
// Each bit spans OVS ticks. Assumes load is only raised while active is low.
module hexdump_tx
    import hexdump_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] data,
    output logic       active,
    output logic       char_done,
    output logic       txd
);
    localparam int OVS_W = $clog2(OVS);
    localparam int BITS  = 8;
    localparam int BIT_W = $clog2(BITS);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

    tx_state_t        state;
    logic [OVS_W-1:0] sub;
    logic [BIT_W-1:0] bit_idx;
    logic [7:0]       shreg;
    logic             bit_end;

    assign bit_end   = tick && (sub == SUB_LAST);
    assign char_done = (state == TX_STOP) && bit_end;
    assign active    = (state != TX_IDLE);

    // Drive the line level from the current frame phase.
    always_comb begin
        case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    // Step through start, data and stop phases on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            sub     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (tick)
                sub <= sub + 1'b1;
            case (state)
                TX_IDLE: begin
                    sub <= '0;
                    if (load) begin
                        shreg <= data;
                        state <= TX_START;
                    end
                end
                TX_START: if (bit_end) begin
                    bit_idx <= '0;
                    state   <= TX_DATA;
                end
                TX_DATA: if (bit_end) begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == BIT_LAST)
                        state <= TX_STOP;
                end
                TX_STOP: if (bit_end)
                    state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hexdump_seq.sv
// Character sequencer: latches the word, hands nibbles out most significant
// first as ASCII, then a line feed, and pulses done after the last frame.
// Assumes the framer is idle whenever load is raised.
module hexdump_seq
    import hexdump_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word_in,
    input  logic              char_done,
    output logic              load,
    output logic [7:0]        char_out,
    output logic              busy,
    output logic              done
);
    localparam int NIBBLES = WORD_W / 4;
    localparam int IDX_W   = $clog2(NIBBLES + 1);
    localparam logic [IDX_W-1:0] IDX_TERM = IDX_W'(NIBBLES);

    seq_state_t        state;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx;

    assign load     = (state == SQ_LOAD);
    assign busy     = (state != SQ_IDLE);
    assign char_out = (idx == IDX_TERM) ? LINE_FEED
                                        : nibble_to_ascii(word_q[WORD_W-1 -: 4]);

    // Accept a word, then advance one character per finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            word_q <= '0;
            idx    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    word_q <= word_in;
                    idx    <= '0;
                    state  <= SQ_LOAD;
                end
                SQ_LOAD: state <= SQ_WAIT;
                SQ_WAIT: if (char_done) begin
                    if (idx == IDX_TERM) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        idx    <= idx + 1'b1;
                        word_q <= word_q << 4;
                        state  <= SQ_LOAD;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hexdump_uart.sv
// Top level of the hex word printer: sequencer, baud tick generator and framer.
// Assumes BAUD_DIV = clk / (16 * baud) - 1 and a WORD_W that is a multiple of 4.
module hexdump_uart #(
    parameter int WORD_W   = 32,
    parameter int BAUD_DIV = 12,
    parameter int DIV_W    = 16,
    parameter int OVS      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word_in,
    output logic              busy,
    output logic              done,
    output logic              txd
);
    logic       tick;
    logic       tx_active;
    logic       char_done;
    logic       load;
    logic [7:0] char_byte;

    hexdump_seq #(.WORD_W(WORD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .word_in   (word_in),
        .char_done (char_done),
        .load      (load),
        .char_out  (char_byte),
        .busy      (busy),
        .done      (done)
    );

    hexdump_baud #(.DIV_W(DIV_W), .BAUD_DIV(BAUD_DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tx_active),
        .tick  (tick)
    );

    hexdump_tx #(.OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .data      (char_byte),
        .active    (tx_active),
        .char_done (char_done),
        .txd       (txd)
    );
endmodule

// File: rtl/hexdump_uart_chk.sv
// Port-level protocol checker for the hex word printer, bound to the top.
module hexdump_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic txd
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);                                          // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                              // R7
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                   // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                         // R9
    AST_FRAME_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> busy);                                    // R6
endmodule

bind hexdump_uart hexdump_uart_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .txd   (txd)
);

// File: tb/hexdump_uart_tb.sv
module hexdump_uart_tb;
    localparam int DIV = 2;
    localparam int BT  = 16 * (DIV + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] word_in = '0;
    logic        busy, done, txd;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rxq[$];
    bit finished = 0;

    always #4 clk = ~clk;

    hexdump_uart #(.BAUD_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
        .busy(busy), .done(done), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [31:0] w, input int i);
        logic [3:0] nib;
        if (i == 8) return 8'h0A;
        nib = w[31 - 4*i -: 4];
        return (nib < 10) ? 8'h30 + nib : 8'h37 + nib;
    endfunction

    // Independent serial receiver sampling each bit at its middle (R6).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                logic [7:0] b;
                repeat (BT/2 - 1) @(negedge clk);
                check(txd === 1'b0, "R6 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BT) @(negedge clk);
                    b[i] = txd;
                end
                repeat (BT) @(negedge clk);
                check(txd === 1'b1, "R6 stop bit", txd, 1);
                rxq.push_back(b);
            end
        end
    end

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int c = 0; c < 20 * 10 * BT; c++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
    endtask

    task automatic compare_word(input logic [31:0] w);
        check(rxq.size() == 9, "R2 character count", rxq.size(), 9);
        for (int i = 0; i < 9; i++) begin
            logic [7:0] got, exp;
            got = (rxq.size() > 0) ? rxq.pop_front() : 8'hxx;
            exp = exp_char(w, i);
            if (i == 8)            check(got === exp, "R5 line feed", got, exp);
            else if (exp < 8'h41)  check(got === exp, "R3 digit char", got, exp);
            else                   check(got === exp, "R4 letter char", got, exp);
        end
        rxq.delete();
    endtask

    // Print one word; inject optionally a mid-word start (R8); return after done.
    task automatic send_word(input logic [31:0] w, input bit inject, input bit from_done);
        bit seen;
        if (!from_done) @(negedge clk);
        start = 1'b1; word_in = w;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, from_done ? "R10 start on done" : "R7 busy after start", busy, 1);
        if (inject) begin
            repeat (BT * 7) @(negedge clk);
            start = 1'b1; word_in = ~w;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b1, "R8 busy kept", busy, 1);
        end
        wait_done(seen);
        check(seen, "R9 done seen", seen, 1);
        check(busy === 1'b0, "R9 busy low with done", busy, 0);
        compare_word(w);
    endtask

    initial begin
        bit seen;
        int unused;
        unused = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset state",
              {txd, busy, done}, 3'b100);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", {txd, busy}, 2'b10);

        send_word(32'h0123_4567, 0, 0);
        @(negedge clk);
        check(done === 1'b0, "R9 done single cycle", done, 0);
        send_word(32'h89AB_CDEF, 0, 0);
        send_word(32'h0000_0000, 0, 0);
        send_word(32'hFFFF_FFFF, 1, 0);
        // R8: no extra frame may follow the ignored start
        repeat (12 * BT) @(negedge clk);
        check(rxq.size() == 0 && txd === 1'b1, "R8 nothing after ignored start",
              rxq.size(), 0);

        // R10: start in the same cycle as done, back to back
        send_word(32'hA5C3_0F19, 0, 0);
        send_word($urandom(), 0, 1);
        for (int k = 0; k < 3; k++) send_word($urandom(), k == 1, 0);
        repeat (12 * BT) @(negedge clk);
        check(rxq.size() == 0, "R2 no stray characters", rxq.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule